// File: doc/BRIEF.md
# General-Purpose Event Aggregator

This block collects up to 32 event flags into a sticky status register with a matching enable register. Software uses a single-cycle register port to read either register, to write the enable register, and to clear status flags by writing ones. An enabled flag that is set becomes one of three requests. It raises a wake pulse while the system sleeps. It raises a system control interrupt (SCI) level while the system is awake and the SCI enable is on. It raises a system management interrupt (SMI) level while the system is awake, the SCI enable is off and the SMI enable is on.

Several flags carry their own rules:
- The software event flag at bit 2 follows a level control input.
- The battery-low flag at bit 10 captures a falling edge of an active-low input, and exists only in mobile mode.
- The two power-management flags at bits 13 and 11 cannot wake a system that was shut down by a power-button override.
- The bus-wake flag at bit 7 never raises SMI.
- Bits 7 and 2 survive the ordinary system reset and are cleared only by the resume-well reset.

Top module: `gpe_event_aggregator`

## Requirements
- R1: A status flag that hardware sets stays set until software writes 1 to its position at reg_addr 0. Writing 0 to a position leaves that flag unchanged.
- R2: Positions 31:19, 17:16, 8, 5 and 0 read as zero in both registers and ignore writes and events. Apart from bits 10 and 2, every valid status bit is set by a high level on its evt_in bit.
- R3: When a hardware set and a write-1 clear reach the same status flag in the same cycle, the flag ends up set.
- R4: With sleep_state 0 (awake), sci is high one cycle after some flag is both set and enabled while sci_en is 1. sci falls one cycle after the last such flag clears. sci is low in every other sleep_state.
- R5: When awake with sci_en 0 and smi_en 1, smi is high on the same terms as sci in R4, except that bit 7 never contributes. sci and smi are never high together.
- R6: With sleep_state 1 to 5, wake is a one-cycle pulse that occurs one cycle after an enabled flag newly becomes set. sci and smi stay low while asleep.
- R7: With sleep_state 5 and pbo_s5 high, bits 13 and 11 produce no wake, while other bits still wake. With pbo_s5 low, bit 13 wakes.
- R8: While swgpe_lvl is high, status bit 2 is set every cycle, even directly after a write-1 clear. evt_in[2] is ignored.
- R9: With mobile_mode 1, a falling edge of batlow_n sets status bit 10, and a steady low level does not set it again. With mobile_mode 0, bit 10 reads zero in both registers and cannot be set. evt_in[10] is ignored.
- R10: rst clears the enable register and every status flag except bits 7 and 2. rsm_rst clears everything, and all outputs start at zero after reset.
- R11: reg_addr 0 selects status and reg_addr 1 selects enable. A write to enable takes effect on the next edge. reg_rdata shows the selected register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| rsm_rst | input | 1 | Synchronous resume-well reset, active high, clears all state |
| evt_in | input | 32 | Per-bit hardware set requests, level high |
| swgpe_lvl | input | 1 | Level control for the software event flag (bit 2) |
| batlow_n | input | 1 | Active-low battery-low signal |
| mobile_mode | input | 1 | 1 = mobile, 0 = desktop (bit 10 reserved) |
| sleep_state | input | 3 | 0 = awake, 1..5 = sleep states |
| pbo_s5 | input | 1 | Deepest sleep was entered by power-button override |
| sci_en | input | 1 | Global SCI enable |
| smi_en | input | 1 | Global SMI enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status, 1 = enable |
| reg_wdata | input | 32 | Write data (write-1-to-clear for status) |
| reg_rdata | output | 32 | Registered read data |
| wake | output | 1 | One-cycle wake pulse |
| sci | output | 1 | SCI request level |
| smi | output | 1 | SMI request level |

## Verification
An event or a write presented before edge k changes status at edge k. A read launched before edge k returns the register's value from just before that edge, after edge k. wake, sci and smi respond to a status change after the following edge, k+1, and a change of sleep_state or a global enable reaches them after a single edge. Each stimulus task queues its expectation stamped with the exact due cycle. The monitor compares the ports on the falling edge of that cycle, so pulse timing and single-cycle width are checked exactly.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int GPE_W = 32;
  // Writable or settable positions: 18, 15:9, 7:6, 4:1
  localparam logic [GPE_W-1:0] VALID_MASK = 32'h0004_FEDE;
  localparam int BIT_SWGPE   = 2;
  localparam int BIT_BUSWAKE = 7;
  localparam int BIT_BATLOW  = 10;
  localparam int BIT_PMA     = 11;
  localparam int BIT_PMB     = 13;
  localparam int SLP_W       = 3;
  localparam logic [SLP_W-1:0] SLP_AWAKE   = 3'd0;
  localparam logic [SLP_W-1:0] SLP_DEEPEST = 3'd5;
  localparam logic [GPE_W-1:0] RSM_ONLY_MASK =
    (GPE_W'(1) << BIT_BUSWAKE) | (GPE_W'(1) << BIT_SWGPE);
  localparam logic [GPE_W-1:0] PM_MASK =
    (GPE_W'(1) << BIT_PMA) | (GPE_W'(1) << BIT_PMB);
endpackage

// File: rtl/gpe_set_logic.sv
module gpe_set_logic
  import gpe_pkg::*;
#(
  parameter int W = GPE_W
) (
  input  logic         clk,
  input  logic         sys_rst,
  input  logic [W-1:0] evt_in,
  input  logic         swgpe_lvl,
  input  logic         batlow_n,
  input  logic         mobile_mode,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] eff_mask
);
  localparam logic [W-1:0] VMASK   = W'(VALID_MASK);
  localparam logic [W-1:0] SPECIAL = (W'(1) << BIT_BATLOW) | (W'(1) << BIT_SWGPE);
  localparam logic [W-1:0] BATBIT  = W'(1) << BIT_BATLOW;

  logic batlow_q;
  logic batlow_fall;

  always_ff @(posedge clk) begin
    if (sys_rst) batlow_q <= 1'b1;
    else         batlow_q <= batlow_n;
  end

  assign batlow_fall = mobile_mode & batlow_q & ~batlow_n;

  always_comb begin
    eff_mask = mobile_mode ? VMASK : (VMASK & ~BATBIT);
    set_vec  = evt_in & VMASK & ~SPECIAL;
    set_vec[BIT_BATLOW] = batlow_fall;
    set_vec[BIT_SWGPE]  = swgpe_lvl;
  end
endmodule

// File: rtl/gpe_regs.sv
module gpe_regs
  import gpe_pkg::*;
#(
  parameter int W = GPE_W,
  parameter logic [W-1:0] RSM_ONLY = W'(RSM_ONLY_MASK)
) (
  input  logic         clk,
  input  logic         sys_rst,
  input  logic         rsm_rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] eff_mask,
  input  logic         reg_we,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] sts,
  output logic [W-1:0] en,
  output logic [W-1:0] reg_rdata
);
  localparam logic [W-1:0] VMASK = W'(VALID_MASK);

  logic [W-1:0] clr;
  logic [W-1:0] sts_nxt;

  assign clr     = (reg_we && !reg_addr) ? reg_wdata : '0;
  // set term applied after clear: a same-cycle set wins
  assign sts_nxt = ((sts & ~clr) | set_vec) & eff_mask;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSM_ONLY[i]) begin : g_rsm
      always_ff @(posedge clk) begin
        if (rsm_rst) sts[i] <= 1'b0;
        else         sts[i] <= sts_nxt[i];
      end
    end else begin : g_sys
      always_ff @(posedge clk) begin
        if (sys_rst) sts[i] <= 1'b0;
        else         sts[i] <= sts_nxt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst)                  en <= '0;
    else if (reg_we && reg_addr)  en <= reg_wdata & eff_mask;
    else                          en <= en & eff_mask;
  end

  always_ff @(posedge clk) begin
    if (sys_rst) reg_rdata <= '0;
    else         reg_rdata <= reg_addr ? en : sts;
  end

  p_sticky_r1: assert property (@(posedge clk) disable iff (sys_rst)
    !$past(sys_rst) |->
      ((($past(sts) & ~$past(clr)) & $past(eff_mask) & eff_mask & ~sts) == '0));

  p_resv_zero_r2: assert property (@(posedge clk) disable iff (sys_rst)
    (reg_rdata & ~VMASK) == '0);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (sys_rst)
    !$past(sys_rst) |-> (($past(set_vec) & eff_mask & ~sts) == '0));
endmodule

// File: rtl/gpe_route.sv
module gpe_route
  import gpe_pkg::*;
#(
  parameter int W = GPE_W
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic [W-1:0]     sts,
  input  logic [W-1:0]     en,
  input  logic [SLP_W-1:0] sleep_state,
  input  logic             pbo_s5,
  input  logic             sci_en,
  input  logic             smi_en,
  output logic             wake,
  output logic             sci,
  output logic             smi
);
  localparam logic [W-1:0] PMM     = W'(PM_MASK);
  localparam logic [W-1:0] NO_SMI  = W'(1) << BIT_BUSWAKE;

  logic [W-1:0] active;
  logic [W-1:0] active_q;
  logic [W-1:0] rise;
  logic [W-1:0] wake_mask;
  logic         asleep;
  logic         wake_n, sci_n, smi_n;

  assign active    = sts & en;
  assign rise      = active & ~active_q;
  assign asleep    = (sleep_state != SLP_AWAKE);
  assign wake_mask = (sleep_state == SLP_DEEPEST && pbo_s5) ? ~PMM : '1;

  always_comb begin
    wake_n = asleep & (|(rise & wake_mask));
    sci_n  = !asleep & sci_en & (|active);
    smi_n  = !asleep & !sci_en & smi_en & (|(active & ~NO_SMI));
  end

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      active_q <= '0;
      wake     <= 1'b0;
      sci      <= 1'b0;
      smi      <= 1'b0;
    end else begin
      active_q <= active;
      wake     <= wake_n;
      sci      <= sci_n;
      smi      <= smi_n;
    end
  end

  p_sci_awake_r4: assert property (@(posedge clk) disable iff (sys_rst)
    sci |-> $past(sleep_state == SLP_AWAKE && sci_en));

  p_smi_gate_r5: assert property (@(posedge clk) disable iff (sys_rst)
    smi |-> $past(sleep_state == SLP_AWAKE && !sci_en && smi_en));

  p_one_req_r5: assert property (@(posedge clk) disable iff (sys_rst)
    !(sci && smi));

  p_wake_asleep_r6: assert property (@(posedge clk) disable iff (sys_rst)
    wake |-> $past(sleep_state != SLP_AWAKE));
endmodule

// File: rtl/gpe_event_aggregator.sv
module gpe_event_aggregator
  import gpe_pkg::*;
#(
  parameter int W = GPE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rsm_rst,
  input  logic [W-1:0]     evt_in,
  input  logic             swgpe_lvl,
  input  logic             batlow_n,
  input  logic             mobile_mode,
  input  logic [SLP_W-1:0] sleep_state,
  input  logic             pbo_s5,
  input  logic             sci_en,
  input  logic             smi_en,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic             wake,
  output logic             sci,
  output logic             smi
);
  logic         sys_rst;
  logic [W-1:0] set_vec;
  logic [W-1:0] eff_mask;
  logic [W-1:0] sts_w;
  logic [W-1:0] en_w;

  assign sys_rst = rst | rsm_rst;

  gpe_set_logic #(.W(W)) i_set (
    .clk(clk), .sys_rst(sys_rst), .evt_in(evt_in), .swgpe_lvl(swgpe_lvl),
    .batlow_n(batlow_n), .mobile_mode(mobile_mode),
    .set_vec(set_vec), .eff_mask(eff_mask)
  );

  gpe_regs #(.W(W)) i_regs (
    .clk(clk), .sys_rst(sys_rst), .rsm_rst(rsm_rst), .set_vec(set_vec),
    .eff_mask(eff_mask), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sts(sts_w), .en(en_w), .reg_rdata(reg_rdata)
  );

  gpe_route #(.W(W)) i_route (
    .clk(clk), .sys_rst(sys_rst), .sts(sts_w), .en(en_w),
    .sleep_state(sleep_state), .pbo_s5(pbo_s5), .sci_en(sci_en),
    .smi_en(smi_en), .wake(wake), .sci(sci), .smi(smi)
  );

  p_swgpe_level_r8: assert property (@(posedge clk) disable iff (rsm_rst)
    (!$past(sys_rst) && $past(swgpe_lvl)) |-> sts_w[BIT_SWGPE]);

  p_batlow_desktop_r9: assert property (@(posedge clk) disable iff (sys_rst)
    (!$past(sys_rst) && !$past(mobile_mode)) |-> (!sts_w[BIT_BATLOW] && !en_w[BIT_BATLOW]));

  p_rst_keep_r10: assert property (@(posedge clk)
    $past(rst && !rsm_rst) |-> ((sts_w & ~W'(RSM_ONLY_MASK)) == '0 && en_w == '0));
endmodule

// File: tb/test_gpe_event_aggregator.sv
module test_gpe_event_aggregator;
  logic        clk = 1'b0;
  logic        rst, rsm_rst;
  logic [31:0] evt_in;
  logic        swgpe_lvl, batlow_n, mobile_mode;
  logic [2:0]  sleep_state;
  logic        pbo_s5, sci_en, smi_en;
  logic        reg_we, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        wake, sci, smi;

  always #5 clk = ~clk;

  gpe_event_aggregator i_gpe_event_aggregator (
    .clk(clk), .rst(rst), .rsm_rst(rsm_rst), .evt_in(evt_in),
    .swgpe_lvl(swgpe_lvl), .batlow_n(batlow_n), .mobile_mode(mobile_mode),
    .sleep_state(sleep_state), .pbo_s5(pbo_s5), .sci_en(sci_en),
    .smi_en(smi_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wake(wake), .sci(sci), .smi(smi)
  );

  typedef struct {
    int          due;
    int          kind;   // 0 rdata, 1 wake, 2 sci, 3 smi
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] act;
        case (sb[i].kind)
          0: act = reg_rdata;
          1: act = {31'd0, wake};
          2: act = {31'd0, sci};
          default: act = {31'd0, smi};
        endcase
        checks++;
        if (act !== sb[i].exp) begin
          errors++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                   sb[i].req, sb[i].kind, cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_at(int d, int kind, logic [31:0] v, string r);
    item_t it;
    it.due = cyc + d; it.kind = kind; it.exp = v; it.req = r;
    sb.push_back(it);
  endtask

  task automatic rd(logic a, logic [31:0] v, string r);
    reg_addr = a;
    expect_at(1, 0, v, r);
    tick();
  endtask

  task automatic wr(logic a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic ev(logic [31:0] m);
    evt_in = m;
    tick();
    evt_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; rsm_rst = 1; evt_in = '0; swgpe_lvl = 0; batlow_n = 1;
    mobile_mode = 1; sleep_state = 0; pbo_s5 = 0; sci_en = 0; smi_en = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = '0;
    repeat (3) tick();
    rst = 0; rsm_rst = 0;

    // R10 reset state
    rd(0, 32'h0, "R10");
    rd(1, 32'h0, "R10");
    expect_at(1, 1, 0, "R10"); expect_at(1, 2, 0, "R10"); expect_at(1, 3, 0, "R10");
    tick();

    // R11 / R2 enable register
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h0004_FEDE, "R2");
    wr(1, 32'h0000_0040);
    rd(1, 32'h0000_0040, "R11");

    // R1 sticky status
    ev(32'h40); tick(); tick();
    rd(0, 32'h40, "R1");
    wr(0, 32'h0);
    rd(0, 32'h40, "R1");
    wr(0, 32'hFFFF_FFBF);
    rd(0, 32'h40, "R1");
    wr(0, 32'h40);
    rd(0, 32'h0, "R1");

    // R2 reserved positions ignore events
    ev(32'hFFFF_FFFF);
    rd(0, 32'h0004_FADA, "R2");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0, "R2");

    // R4 SCI level
    sci_en = 1;
    expect_at(2, 2, 1, "R4"); expect_at(2, 3, 0, "R4");
    ev(32'h40); tick();
    expect_at(1, 2, 1, "R4"); expect_at(2, 2, 0, "R4");
    wr(0, 32'h40); tick(); tick();

    // R5 SMI routing
    sci_en = 0; smi_en = 1;
    expect_at(2, 3, 1, "R5"); expect_at(2, 2, 0, "R5");
    ev(32'h40); tick();
    expect_at(2, 3, 0, "R5");
    wr(0, 32'h40); tick(); tick();
    wr(1, 32'h80);
    expect_at(2, 3, 0, "R5"); expect_at(3, 3, 0, "R5");
    ev(32'h80); tick();
    rd(0, 32'h80, "R5");
    expect_at(1, 2, 1, "R4");
    sci_en = 1;
    tick(); tick();
    wr(0, 32'h80); tick(); tick();

    // R3 set beats clear
    wr(1, 32'h40);
    ev(32'h40); tick();
    evt_in = 32'h40; reg_we = 1; reg_addr = 0; reg_wdata = 32'h40;
    tick();
    evt_in = '0; reg_we = 0; reg_wdata = '0;
    expect_at(1, 2, 1, "R3");
    rd(0, 32'h40, "R3");
    wr(0, 32'h40); tick(); tick();

    // R6 wake pulse while asleep
    sleep_state = 3; tick();
    expect_at(2, 1, 1, "R6"); expect_at(3, 1, 0, "R6"); expect_at(2, 2, 0, "R6");
    ev(32'h40); tick(); tick();
    wr(0, 32'h40); tick();

    // R7 power-button override exception
    sleep_state = 5; pbo_s5 = 1;
    wr(1, 32'h2840); tick();
    expect_at(2, 1, 0, "R7"); ev(32'h2000);
    expect_at(2, 1, 0, "R7"); ev(32'h0800);
    expect_at(2, 1, 1, "R7"); ev(32'h0040);
    tick(); tick();
    wr(0, 32'hFFFF_FFFF); tick();
    pbo_s5 = 0; tick();
    expect_at(2, 1, 1, "R7"); ev(32'h2000);
    tick(); tick();
    wr(0, 32'hFFFF_FFFF);
    sleep_state = 0; tick();

    // R8 level-driven software flag
    swgpe_lvl = 1; tick(); tick();
    rd(0, 32'h4, "R8");
    wr(0, 32'h4);
    rd(0, 32'h4, "R8");
    ev(32'h0);
    swgpe_lvl = 0; tick();
    wr(0, 32'h4);
    rd(0, 32'h0, "R8");

    // R9 battery-low edge and desktop mode
    batlow_n = 0; tick(); tick();
    rd(0, 32'h400, "R9");
    wr(0, 32'h400); tick();
    rd(0, 32'h0, "R9");
    batlow_n = 1; tick();
    mobile_mode = 0; tick();
    batlow_n = 0; tick(); tick();
    rd(0, 32'h0, "R9");
    wr(1, 32'h400);
    rd(1, 32'h0, "R9");
    batlow_n = 1; mobile_mode = 1; tick();

    // R10 reset domains
    wr(1, 32'h40);
    ev(32'hC0);
    swgpe_lvl = 1; tick();
    swgpe_lvl = 0; tick();
    rd(0, 32'hC4, "R10");
    rst = 1; tick(); rst = 0;
    expect_at(1, 2, 0, "R10");
    rd(0, 32'h84, "R10");
    rd(1, 32'h0, "R10");
    rsm_rst = 1; tick(); rsm_rst = 0;
    rd(0, 32'h0, "R10");

    repeat (5) tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule